// File: doc/BRIEF.md
# Three-Wire Tuner Control Register

This block receives a serial control word over three wires (enable, data and serial clock) and holds the settings of a tuner synthesizer. The settings are a band-select nibble, a 10-bit main divider count M, a 5-bit swallow count S and an 8-bit test field. All three serial lines are brought into a faster system clock domain through synchronizers. A falling edge of the serial clock is detected there, and each such edge moves one data bit into the frame.

A frame opens when enable rises and closes when it falls. The three groups are committed at fixed pulse counts within the frame. The band nibble is committed after the 4th pulse. M and S are committed together after the 19th pulse. The test field is committed after the 27th pulse. A short frame therefore updates only the groups it fully delivered. Extra pulses after the 27th are ignored until enable is lowered again.

Each commit raises one bit of a one-cycle update strobe, in the same cycle that the group's outputs change.

Top module: `tcr_port`

## Requirements
- R1: After reset, `band_o` is 0, `m_o` is 32, `s_o` is 0, `test_o` is 8'h80 and `upd_o` is 0.
- R2: A data bit is taken only on a falling edge of `ctl_sclk_i` while `ctl_en_i` is high. Serial clock edges with enable low change no output.
- R3: Bits arrive most significant first. The first four bits go to `band_o[3]` down to `band_o[0]`. The next ten go to `m_o[9]` down to `m_o[0]`. The next five go to `s_o[4]` down to `s_o[0]`. The last eight go to `test_o[7]` down to `test_o[0]`.
- R4: `band_o` is committed on the 4th pulse of a frame, whether or not the frame goes on to the 19th pulse. A frame of fewer than 4 pulses leaves `band_o` unchanged.
- R5: `m_o` and `s_o` are committed together on the 19th pulse.
- R6: A frame that ends before its 19th pulse leaves `m_o` and `s_o` unchanged.
- R7: `test_o` is committed only on the 27th pulse. A frame of 19 to 26 pulses leaves it unchanged.
- R8: `test_o[7]` is the mandatory-one bit. A 27-pulse frame whose 8th-from-last bit is 0 leaves `test_o` unchanged, but it still commits band, M and S.
- R9: Pulses after the 27th are ignored until enable goes low. The next frame is then received normally.
- R10: `upd_o[0]` (band), `upd_o[1]` (M/S) and `upd_o[2]` (test) are each high for exactly one cycle, in the cycle the corresponding outputs take their new value. At most one bit is high at a time.
- R11: With `SYNC_STAGES` = 2, a commit becomes visible after the 2nd system clock edge following the first edge that samples the serial clock low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en_i | input | 1 | Serial frame enable |
| ctl_dat_i | input | 1 | Serial data |
| ctl_sclk_i | input | 1 | Serial clock, bit taken on falling edge |
| band_o | output | BAND_W | Band select bits, 1 = on |
| m_o | output | M_W | Main divider count |
| s_o | output | S_W | Swallow divider count |
| test_o | output | TEST_W | Test field, bit 7 mandatory one |
| upd_o | output | 3 | One-cycle commit strobes: band, M/S, test |

## Verification
Each serial clock fall is seen by the logic only after the synchronizer and edge register. A committed group therefore appears exactly two system clock edges after the first edge that samples the serial clock low. The strobe for that group is high in that same cycle and is gone one cycle later.

The bench keeps a history of the inputs as they were at past clock edges. From that history its behavioural model computes when each commit is due, and the bench compares every output against the model on the falling system clock edge of every cycle. A one-cycle slip in any field or strobe is therefore reported at once. After each frame has settled, fixed end-of-frame values are checked on top of the per-cycle comparison.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
   // commit pulses, bit order matches upd_o: [2] test, [1] divider, [0] band
   typedef struct packed {
      logic test;
      logic div;
      logic band;
   } commit_t;

   localparam int unsigned COMMIT_W = 3;
endpackage

// File: rtl/tcr_sync.sv
module tcr_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tcr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d_i};
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/tcr_frame_ctr.sv
module tcr_frame_ctr
   import tcr_pkg::*;
#(
   parameter int BAND_PT = 4,
   parameter int DIV_PT  = 19,
   parameter int TEST_PT = 27,
   parameter int CNT_W   = 5
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    en_i,
   input  logic    fall_i,
   output logic    shift_o,
   output commit_t commit_o
);
   generate
      if (!(BAND_PT < DIV_PT && DIV_PT < TEST_PT)) begin : g_bad_points
         $error("tcr_frame_ctr: commit points must ascend");
      end
      if ((1 << CNT_W) <= TEST_PT) begin : g_bad_cnt
         $error("tcr_frame_ctr: CNT_W too narrow");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc = cnt + CNT_W'(1);
   // saturate at the last commit point: later pulses are dropped
   assign shift_o = en_i & fall_i & (cnt != CNT_W'(TEST_PT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!en_i)   cnt <= '0;
      else if (shift_o) cnt <= cnt_inc;
   end

   always_comb begin
      commit_o      = '0;
      commit_o.band = shift_o && (cnt_inc == CNT_W'(BAND_PT));
      commit_o.div  = shift_o && (cnt_inc == CNT_W'(DIV_PT));
      commit_o.test = shift_o && (cnt_inc == CNT_W'(TEST_PT));
   end

   // R9
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (cnt == '0));
   // R9
   cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(TEST_PT));
endmodule

// File: rtl/tcr_shreg.sv
module tcr_shreg #(
   parameter int W = 15
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_i,
   input  logic         bit_i,
   output logic [W-1:0] next_o
);
   logic [W-1:0] sh;

   assign next_o = {sh[W-2:0], bit_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sh <= '0;
      else if (shift_i) sh <= next_o;
   end
endmodule

// File: rtl/tcr_port.sv
module tcr_port
   import tcr_pkg::*;
#(
   parameter int              BAND_W      = 4,
   parameter int              M_W         = 10,
   parameter int              S_W         = 5,
   parameter int              TEST_W      = 8,
   parameter int              SYNC_STAGES = 2,
   parameter bit              CHECK_SI    = 1'b1,
   parameter logic [M_W-1:0]  DEF_M       = M_W'(32),
   parameter logic [S_W-1:0]  DEF_S       = S_W'(0),
   parameter logic [TEST_W-1:0] DEF_TEST  = TEST_W'(8'h80)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_en_i,
   input  logic              ctl_dat_i,
   input  logic              ctl_sclk_i,
   output logic [BAND_W-1:0] band_o,
   output logic [M_W-1:0]    m_o,
   output logic [S_W-1:0]    s_o,
   output logic [TEST_W-1:0] test_o,
   output logic [2:0]        upd_o
);
   localparam int DIV_W   = M_W + S_W;
   localparam int BAND_PT = BAND_W;
   localparam int DIV_PT  = BAND_W + DIV_W;
   localparam int TEST_PT = DIV_PT + TEST_W;
   localparam int CNT_W   = $clog2(TEST_PT + 1);
   localparam int MX1     = (DIV_W > BAND_W) ? DIV_W : BAND_W;
   localparam int SH_W    = (TEST_W > MX1) ? TEST_W : MX1;

   generate
      if (BAND_W < 1 || M_W < 1 || S_W < 1 || TEST_W < 1) begin : g_bad_w
         $error("tcr_port: field widths must be positive");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tcr_port: SYNC_STAGES must be at least 2");
      end
      if (CHECK_SI && !DEF_TEST[TEST_W-1]) begin : g_bad_def
         $error("tcr_port: DEF_TEST must carry the mandatory one bit");
      end
   endgenerate

   // synchronised lines: [2] enable, [1] data, [0] serial clock
   logic [2:0] in_raw, in_s;
   assign in_raw = {ctl_en_i, ctl_dat_i, ctl_sclk_i};

   tcr_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (in_raw),
      .q_o   (in_s)
   );

   logic sclk_q;
   logic fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= in_s[0];
   end

   assign fall = sclk_q & ~in_s[0];

   logic    shift;
   commit_t commit;

   tcr_frame_ctr #(
      .BAND_PT (BAND_PT),
      .DIV_PT  (DIV_PT),
      .TEST_PT (TEST_PT),
      .CNT_W   (CNT_W)
   ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (in_s[2]),
      .fall_i   (fall),
      .shift_o  (shift),
      .commit_o (commit)
   );

   logic [SH_W-1:0] sh_next;

   tcr_shreg #(.W(SH_W)) u_sh (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (shift),
      .bit_i   (in_s[1]),
      .next_o  (sh_next)
   );

   logic test_ok;
   generate
      if (CHECK_SI) begin : g_si_gate
         assign test_ok = sh_next[TEST_W-1];
      end else begin : g_si_open
         assign test_ok = 1'b1;
      end
   endgenerate

   commit_t upd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         band_o <= '0;
         m_o    <= DEF_M;
         s_o    <= DEF_S;
         test_o <= DEF_TEST;
         upd_q  <= '0;
      end else begin
         upd_q      <= '0;
         if (commit.band) begin
            band_o     <= sh_next[BAND_W-1:0];
            upd_q.band <= 1'b1;
         end
         if (commit.div) begin
            m_o       <= sh_next[DIV_W-1:S_W];
            s_o       <= sh_next[S_W-1:0];
            upd_q.div <= 1'b1;
         end
         if (commit.test && test_ok) begin
            test_o     <= sh_next[TEST_W-1:0];
            upd_q.test <= 1'b1;
         end
      end
   end

   assign upd_o = upd_q;

   // R4
   band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_o[0] |-> $stable(band_o));
   // R6
   div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_o[1] |-> ($stable(m_o) && $stable(s_o)));
   // R7
   test_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_o[2] |-> $stable(test_o));
   // R10
   upd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(upd_o));

   generate
      if (CHECK_SI) begin : g_si_chk
         // R8
         si_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
            test_o[TEST_W-1]);
      end
   endgenerate
endmodule

// File: tb/test_tcr_port.sv
module test_tcr_port;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_SER   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_en_i = 1'b0;
   logic ctl_dat_i = 1'b0;
   logic ctl_sclk_i = 1'b0;
   logic [3:0] band_o;
   logic [9:0] m_o;
   logic [4:0] s_o;
   logic [7:0] test_o;
   logic [2:0] upd_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tcr_port i_tcr_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_en_i   (ctl_en_i),
      .ctl_dat_i  (ctl_dat_i),
      .ctl_sclk_i (ctl_sclk_i),
      .band_o     (band_o),
      .m_o        (m_o),
      .s_o        (s_o),
      .test_o     (test_o),
      .upd_o      (upd_o)
   );

   // behavioural reference: history of sampled inputs, bits kept in a queue
   bit h_sclk [3];
   bit h_en   [3];
   bit h_dat  [3];
   bit bits_q [$];
   int r_cnt;
   logic [3:0] r_band;
   logic [9:0] r_m;
   logic [4:0] r_s;
   logic [7:0] r_test;
   logic [2:0] r_upd;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) begin
            h_sclk[i] = 1'b0; h_en[i] = 1'b0; h_dat[i] = 1'b0;
         end
         bits_q.delete();
         r_cnt = 0; r_band = 4'h0; r_m = 10'd32; r_s = 5'd0;
         r_test = 8'h80; r_upd = 3'b000;
      end else begin
         r_upd = 3'b000;
         if (!h_en[1]) begin
            r_cnt = 0;
            bits_q.delete();
         end else if (h_sclk[2] && !h_sclk[1] && r_cnt < 27) begin
            bits_q.push_back(h_dat[1]);
            r_cnt++;
            if (r_cnt == 4) begin
               for (int i = 0; i < 4; i++) r_band[3-i] = bits_q[i];
               r_upd[0] = 1'b1;
            end
            if (r_cnt == 19) begin
               for (int i = 0; i < 10; i++) r_m[9-i] = bits_q[4+i];
               for (int i = 0; i < 5; i++) r_s[4-i] = bits_q[14+i];
               r_upd[1] = 1'b1;
            end
            if (r_cnt == 27 && bits_q[19]) begin
               for (int i = 0; i < 8; i++) r_test[7-i] = bits_q[19+i];
               r_upd[2] = 1'b1;
            end
         end
      end
      for (int i = 2; i > 0; i--) begin
         h_sclk[i] = h_sclk[i-1]; h_en[i] = h_en[i-1]; h_dat[i] = h_dat[i-1];
      end
      h_sclk[0] = ctl_sclk_i; h_en[0] = ctl_en_i; h_dat[0] = ctl_dat_i;
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model (R5, R10, R11 timing)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R4", "band cycle", 32'(band_o), 32'(r_band));
         check("R5", "m cycle", 32'(m_o), 32'(r_m));
         check("R5", "s cycle", 32'(s_o), 32'(r_s));
         check("R7", "test cycle", 32'(test_o), 32'(r_test));
         check("R10", "upd cycle", 32'(upd_o), 32'(r_upd));
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // sends n frame bits from w (MSB first), then extra pulses carrying xbit
   task automatic send(input logic [26:0] w, input int n, input int extra, input bit xbit);
      ctl_en_i = 1'b1;
      wait_clk(HALF_SER);
      for (int i = 0; i < n + extra; i++) begin
         ctl_dat_i = (i < n) ? w[26-i] : xbit;
         ctl_sclk_i = 1'b1;
         wait_clk(HALF_SER);
         ctl_sclk_i = 1'b0;
         wait_clk(HALF_SER);
      end
      wait_clk(2);
      ctl_en_i = 1'b0;
      ctl_dat_i = 1'b0;
      wait_clk(8);
   endtask

   task automatic expect_all(input string req, input logic [3:0] b, input logic [9:0] m,
                             input logic [4:0] s, input logic [7:0] t);
      check(req, "band", 32'(band_o), 32'(b));
      check(req, "m", 32'(m_o), 32'(m));
      check(req, "s", 32'(s_o), 32'(s));
      check(req, "test", 32'(test_o), 32'(t));
      check(req, "upd idle", 32'(upd_o), 32'(0));
   endtask

   initial begin
      wait_clk(3);
      expect_all("R1", 4'h0, 10'd32, 5'd0, 8'h80);
      rst_n = 1'b1;
      wait_clk(3);
      expect_all("R1", 4'h0, 10'd32, 5'd0, 8'h80);

      // R3 R5 R7: full frame
      send({4'b1010, 10'h2A5, 5'h13, 8'hD5}, 27, 0, 1'b0);
      expect_all("R3", 4'b1010, 10'h2A5, 5'h13, 8'hD5);

      // R7: 19-pulse frame keeps test field
      send({4'b0101, 10'h155, 5'h0A, 8'hFF}, 19, 0, 1'b0);
      expect_all("R7", 4'b0101, 10'h155, 5'h0A, 8'hD5);

      // R4 R6: enable drops after 10 pulses
      send({4'b1100, 10'h3C3, 5'h11, 8'h80}, 10, 0, 1'b0);
      expect_all("R6", 4'b1100, 10'h155, 5'h0A, 8'hD5);

      // R4: 3 pulses change nothing
      send({4'b0011, 10'h000, 5'h00, 8'h80}, 3, 0, 1'b0);
      expect_all("R4", 4'b1100, 10'h155, 5'h0A, 8'hD5);

      // R2: serial clock toggles with enable low
      for (int i = 0; i < 30; i++) begin
         ctl_dat_i = i[0];
         ctl_sclk_i = 1'b1;
         wait_clk(HALF_SER);
         ctl_sclk_i = 1'b0;
         wait_clk(HALF_SER);
      end
      wait_clk(6);
      expect_all("R2", 4'b1100, 10'h155, 5'h0A, 8'hD5);

      // R8: mandatory-one bit clear
      send({4'b0110, 10'h3FF, 5'h1F, 8'h7F}, 27, 0, 1'b0);
      expect_all("R8", 4'b0110, 10'h3FF, 5'h1F, 8'hD5);

      // R9: pulses beyond the 27th
      send({4'b1001, 10'h020, 5'h00, 8'hA6}, 27, 6, 1'b1);
      expect_all("R9", 4'b1001, 10'h020, 5'h00, 8'hA6);

      // R9: next frame after re-arm
      send({4'b1111, 10'h001, 5'h01, 8'h80}, 27, 0, 1'b0);
      expect_all("R9", 4'b1111, 10'h001, 5'h01, 8'h80);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule